// File: doc/BRIEF.md
# Clock Configuration Frame Loader

This block takes a byte stream from a host link, one byte per accepted handshake, and breaks it into frames. Each frame starts with a four-byte header (type tag, flag byte, 16-bit word count) and carries that many 64-bit payload words. Frames with the right tag fill a 32-entry table of 40-bit clock-reconfiguration words. A transfer can be one frame or several. The begin flag rewinds the write pointer. The end flag asks for the loaded table to be applied.

Once the end-flagged frame is stored and the table is exactly full, the block gives a downstream reconfiguration sequencer a one-cycle start pulse. It then stays busy, and refuses further bytes, until that sequencer signals done. The sequencer reads the table through a combinational read port. A transfer is abandoned and a sticky error flag is raised in three cases: a frame arrives without a transfer open, a frame would push the pointer past the table, or the end frame leaves the table short. The next begin-flagged frame clears the error.

The controller is a state machine with these states:

- Header states: ST_TAG, ST_FLAGS, ST_LEN_LO and ST_LEN_HI take one header byte each.
- ST_WORDS stores the payload.
- ST_DRAIN discards the payload of a rejected frame.
- ST_LAUNCH raises the start pulse.
- ST_WAIT holds the block busy.

Transitions:

- Each header state advances on an accepted byte.
- ST_LEN_HI goes to ST_WORDS for an accepted frame with words.
- ST_LEN_HI goes to ST_DRAIN for a foreign or rejected frame with words.
- ST_LEN_HI goes to ST_TAG for a zero-count frame that ends nothing.
- ST_LEN_HI goes to ST_LAUNCH for a zero-count end frame that finds the table full.
- ST_WORDS goes to ST_TAG or ST_LAUNCH after its last word.
- ST_DRAIN goes to ST_TAG after its last byte.
- ST_LAUNCH goes to ST_WAIT after one cycle.
- ST_WAIT goes to ST_TAG when done is seen.

Top module: `clkcfg_loader`

## Requirements
- R1: A frame is byte 0 tag, byte 1 flags, bytes 2 and 3 a little-endian word count N (byte 2 low), then 8·N payload bytes. The next frame starts right after.
- R2: Each payload word is 8 bytes, least significant first. Its low 40 bits (bytes 0 to 4) go to the table entry at the write pointer, and the pointer then advances by one.
- R3: A matching frame with flag bit 0 (begin) set, and not rejected by R6, sets the pointer to 0 before its words are stored, opens a transfer and clears the error flag.
- R4: A frame whose tag differs from the parameter TAG (default 0x5C) is consumed in full. It has no effect on the table, the pointer, the error flag or the start pulse.
- R5: A matching frame without the begin flag while no transfer is open sets the error flag. Its payload is discarded.
- R6: A matching frame whose base pointer (0 if begin, else the current pointer) plus N exceeds 32 sets the error flag, closes the transfer and discards the payload. The pointer never exceeds 32.
- R7: After the last word of a frame with flag bit 1 (end) is stored, or at its header if N is 0, the transfer closes. If the pointer equals 32, a start pulse follows; otherwise the error flag is set and no pulse is issued.
- R8: The start pulse lasts exactly one cycle and is visible in the cycle after the final byte is accepted. Busy is high from the pulse until the cycle after done is sampled. rx_ready is low throughout that time.
- R9: tbl_rd_data shows, combinationally, the entry selected by tbl_rd_addr. All entries are zero after reset.
- R10: A single frame carrying both begin and end flags with 32 words loads the whole table and starts the apply step.
- R11: A transfer split across frames of 12, 12 and 8 words (begin, none, end) loads all 32 entries in order and starts the apply step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte valid |
| rx_data | input | 8 | Host byte |
| rx_ready | output | 1 | Byte accepted when high with rx_valid |
| apply_start | output | 1 | One-cycle request to the reconfiguration sequencer |
| apply_busy | output | 1 | Apply step in progress; input blocked |
| apply_done | input | 1 | Sequencer finished |
| load_error | output | 1 | Sticky transfer error |
| tbl_rd_addr | input | 5 | Table read index |
| tbl_rd_data | output | 40 | Table entry at tbl_rd_addr |

## Verification
The assertions watch, on every cycle, that:

- the write pointer stays within 32;
- no write happens with the pointer at 32;
- the start pulse lasts one cycle and is followed by busy;
- the start pulse only appears with a full table;
- the error flag only rises at a header or after a stored word.

Only the bench's scenarios can show that:

- the right words land in the right entries across split transfers and pointer rewinds;
- foreign frames and rejected payloads leave the table untouched;
- a begin frame clears a stale error;
- bytes offered during the busy window are refused.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        ST_TAG,
        ST_FLAGS,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_WORDS,
        ST_DRAIN,
        ST_LAUNCH,
        ST_WAIT
    } ld_state_t;

    localparam int FLAG_BEGIN_BIT = 0;
    localparam int FLAG_END_BIT   = 1;
    localparam int BYTES_PER_WORD = 8;

endpackage

// File: rtl/clkcfg_word_packer.sv
module clkcfg_word_packer #(
    parameter int WORD_W         = 40,
    parameter int BYTES_PER_WORD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_en,
    input  logic [7:0]        byte_data,
    output logic [WORD_W-1:0] word,
    output logic              word_done
);
    localparam int KEEP  = (WORD_W + 7) / 8;
    localparam int IDX_W = $clog2(BYTES_PER_WORD);

    logic [IDX_W-1:0]  idx_q;
    logic [KEEP*8-1:0] lanes_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (byte_en) begin
            if (idx_q == IDX_W'(BYTES_PER_WORD - 1)) idx_q <= '0;
            else                                     idx_q <= idx_q + 1'b1;
        end
    end

    // One register lane per kept byte; bytes past KEEP are dropped.
    for (genvar g = 0; g < KEEP; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) lanes_q[g*8 +: 8] <= '0;
            else if (byte_en && idx_q == IDX_W'(g)) lanes_q[g*8 +: 8] <= byte_data;
        end
    end

    assign word      = lanes_q[WORD_W-1:0];
    assign word_done = byte_en && (idx_q == IDX_W'(BYTES_PER_WORD - 1));

    // R2: a completed word always leaves the byte index at the start of the next word
    assert_idx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (idx_q == '0));

endmodule

// File: rtl/clkcfg_table.sv
module clkcfg_table #(
    parameter int ENTRIES = 32,
    parameter int WORD_W  = 40,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/clkcfg_frame_ctrl.sv
module clkcfg_frame_ctrl
    import clkcfg_pkg::*;
#(
    parameter int         ENTRIES = 32,
    parameter logic [7:0] TAG     = 8'h5C,
    localparam int        AW      = $clog2(ENTRIES),
    localparam int        PTR_W   = $clog2(ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_fire,
    input  logic [7:0]    byte_data,
    input  logic          word_done,
    input  logic          apply_done,
    output logic          rx_ready,
    output logic          in_words,
    output logic          tbl_we,
    output logic [AW-1:0] tbl_waddr,
    output logic          apply_start,
    output logic          apply_busy,
    output logic          load_error
);
    localparam int CNT_W   = 16;
    localparam int DRAIN_W = CNT_W + 3;

    ld_state_t          state_q, state_d;
    logic               tag_hit_q, tag_hit_d;
    logic               beg_q, beg_d;
    logic               end_q, end_d;
    logic [7:0]         len_lo_q, len_lo_d;
    logic [CNT_W-1:0]   words_left_q, words_left_d;
    logic [DRAIN_W-1:0] drain_q, drain_d;
    logic [PTR_W-1:0]   wptr_q, wptr_d;
    logic               open_q, open_d;
    logic               err_q, err_d;

    logic [CNT_W-1:0]   hdr_cnt;
    logic [PTR_W-1:0]   base_ptr;
    logic [CNT_W:0]     reach;

    assign hdr_cnt  = {byte_data, len_lo_q};
    assign base_ptr = beg_q ? '0 : wptr_q;
    assign reach    = {1'b0, hdr_cnt} + (CNT_W+1)'(base_ptr);

    // State register and header/pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_TAG;
            tag_hit_q    <= 1'b0;
            beg_q        <= 1'b0;
            end_q        <= 1'b0;
            len_lo_q     <= '0;
            words_left_q <= '0;
            drain_q      <= '0;
            wptr_q       <= '0;
            open_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            state_q      <= state_d;
            tag_hit_q    <= tag_hit_d;
            beg_q        <= beg_d;
            end_q        <= end_d;
            len_lo_q     <= len_lo_d;
            words_left_q <= words_left_d;
            drain_q      <= drain_d;
            wptr_q       <= wptr_d;
            open_q       <= open_d;
            err_q        <= err_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d      = state_q;
        tag_hit_d    = tag_hit_q;
        beg_d        = beg_q;
        end_d        = end_q;
        len_lo_d     = len_lo_q;
        words_left_d = words_left_q;
        drain_d      = drain_q;
        wptr_d       = wptr_q;
        open_d       = open_q;
        err_d        = err_q;
        unique case (state_q)
            ST_TAG: if (byte_fire) begin
                tag_hit_d = (byte_data == TAG);
                state_d   = ST_FLAGS;
            end
            ST_FLAGS: if (byte_fire) begin
                beg_d   = byte_data[FLAG_BEGIN_BIT];
                end_d   = byte_data[FLAG_END_BIT];
                state_d = ST_LEN_LO;
            end
            ST_LEN_LO: if (byte_fire) begin
                len_lo_d = byte_data;
                state_d  = ST_LEN_HI;
            end
            ST_LEN_HI: if (byte_fire) begin
                drain_d      = {hdr_cnt, 3'b000};
                words_left_d = hdr_cnt;
                if (!tag_hit_q) begin
                    state_d = (hdr_cnt == '0) ? ST_TAG : ST_DRAIN;
                end else if (!beg_q && !open_q) begin
                    err_d   = 1'b1;
                    state_d = (hdr_cnt == '0) ? ST_TAG : ST_DRAIN;
                end else if (reach > (CNT_W+1)'(ENTRIES)) begin
                    err_d   = 1'b1;
                    open_d  = 1'b0;
                    state_d = ST_DRAIN;
                end else begin
                    if (beg_q) begin
                        wptr_d = '0;
                        err_d  = 1'b0;
                    end
                    open_d = 1'b1;
                    if (hdr_cnt != '0) begin
                        state_d = ST_WORDS;
                    end else if (end_q) begin
                        open_d = 1'b0;
                        if (base_ptr == PTR_W'(ENTRIES)) begin
                            state_d = ST_LAUNCH;
                        end else begin
                            err_d   = 1'b1;
                            state_d = ST_TAG;
                        end
                    end else begin
                        state_d = ST_TAG;
                    end
                end
            end
            ST_WORDS: if (word_done) begin
                wptr_d       = wptr_q + 1'b1;
                words_left_d = words_left_q - 1'b1;
                if (words_left_q == CNT_W'(1)) begin
                    state_d = ST_TAG;
                    if (end_q) begin
                        open_d = 1'b0;
                        if (wptr_q + 1'b1 == PTR_W'(ENTRIES)) state_d = ST_LAUNCH;
                        else                                 err_d   = 1'b1;
                    end
                end
            end
            ST_DRAIN: if (byte_fire) begin
                drain_d = drain_q - 1'b1;
                if (drain_q == DRAIN_W'(1)) state_d = ST_TAG;
            end
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (apply_done) state_d = ST_TAG;
        endcase
    end

    // Outputs
    always_comb begin
        rx_ready    = !(state_q == ST_LAUNCH || state_q == ST_WAIT);
        in_words    = (state_q == ST_WORDS);
        apply_start = (state_q == ST_LAUNCH);
        apply_busy  = (state_q == ST_LAUNCH) || (state_q == ST_WAIT);
        tbl_we      = (state_q == ST_WORDS) && word_done;
        tbl_waddr   = wptr_q[AW-1:0];
        load_error  = err_q;
    end

    assert_ptr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q <= PTR_W'(ENTRIES));

    assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (wptr_q < PTR_W'(ENTRIES)));

    assert_full_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        apply_start |-> (wptr_q == PTR_W'(ENTRIES)));

    assert_start_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_start |=> !apply_start);

    assert_start_then_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_start |=> apply_busy);

    // R5: the error flag only rises from a header decision or a completed word
    assert_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(state_q) == ST_LEN_HI || $past(state_q) == ST_WORDS));

endmodule

// File: rtl/clkcfg_loader.sv
module clkcfg_loader
    import clkcfg_pkg::*;
#(
    parameter int         ENTRIES = 32,
    parameter int         WORD_W  = 40,
    parameter logic [7:0] TAG     = 8'h5C,
    localparam int        AW      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              apply_start,
    output logic              apply_busy,
    input  logic              apply_done,
    output logic              load_error,
    input  logic [AW-1:0]     tbl_rd_addr,
    output logic [WORD_W-1:0] tbl_rd_data
);
    logic              byte_fire;
    logic              in_words;
    logic              word_done;
    logic [WORD_W-1:0] word;
    logic              tbl_we;
    logic [AW-1:0]     tbl_waddr;

    assign byte_fire = rx_valid && rx_ready;

    clkcfg_frame_ctrl #(
        .ENTRIES (ENTRIES),
        .TAG     (TAG)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_fire   (byte_fire),
        .byte_data   (rx_data),
        .word_done   (word_done),
        .apply_done  (apply_done),
        .rx_ready    (rx_ready),
        .in_words    (in_words),
        .tbl_we      (tbl_we),
        .tbl_waddr   (tbl_waddr),
        .apply_start (apply_start),
        .apply_busy  (apply_busy),
        .load_error  (load_error)
    );

    clkcfg_word_packer #(
        .WORD_W         (WORD_W),
        .BYTES_PER_WORD (BYTES_PER_WORD)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!in_words),
        .byte_en   (byte_fire && in_words),
        .byte_data (rx_data),
        .word      (word),
        .word_done (word_done)
    );

    clkcfg_table #(
        .ENTRIES (ENTRIES),
        .WORD_W  (WORD_W)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr (tbl_waddr),
        .wdata (word),
        .raddr (tbl_rd_addr),
        .rdata (tbl_rd_data)
    );

endmodule

// File: tb/clkcfg_loader_bench.sv
module clkcfg_loader_bench;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] TAG        = 8'h5C;
    localparam int         N          = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        apply_start, apply_busy, load_error;
    logic        apply_done = 1'b0;
    logic [4:0]  tbl_rd_addr = '0;
    logic [39:0] tbl_rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_loader u_clkcfg_loader (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .apply_start(apply_start), .apply_busy(apply_busy),
        .apply_done(apply_done), .load_error(load_error),
        .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural reference model state
    int          m_pos = 0, m_cnt = 0, m_lo = 0, m_ptr = 0;
    bit          m_tag = 0, m_beg = 0, m_end = 0, m_open = 0, m_err = 0;
    bit          m_store = 0, m_start = 0, m_busy = 0;
    logic [63:0] m_word = '0;
    logic [39:0] m_tab [N];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(apply_start == m_start, {req, " start"}, apply_start, m_start);
        chk(apply_busy == m_busy, {req, " busy"}, apply_busy, m_busy);
        chk(load_error == m_err, {req, " error"}, load_error, m_err);
    endtask

    task automatic finish_frame();
        if (m_end) begin
            m_open = 0;
            if (m_ptr == N) begin m_start = 1; m_busy = 1; end
            else m_err = 1;
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (m_pos == 0) m_tag = (b == TAG);
        else if (m_pos == 1) begin m_beg = b[0]; m_end = b[1]; end
        else if (m_pos == 2) m_lo = b;
        else if (m_pos == 3) begin
            int base;
            m_cnt = (int'(b) << 8) | m_lo;
            m_store = 0;
            base = m_beg ? 0 : m_ptr;
            if (!m_tag) ;
            else if (!m_beg && !m_open) m_err = 1;
            else if (base + m_cnt > N) begin m_err = 1; m_open = 0; end
            else begin
                if (m_beg) begin m_ptr = 0; m_err = 0; end
                m_open = 1; m_store = 1;
                if (m_cnt == 0) finish_frame();
            end
        end else begin
            int k;
            k = (m_pos - 4) % 8;
            m_word[k*8 +: 8] = b;
            if (k == 7 && m_store) begin
                m_tab[m_ptr] = m_word[39:0];
                m_ptr++;
                if (m_pos == 3 + 8*m_cnt) finish_frame();
            end
        end
        m_pos++;
        if (m_pos >= 4 && m_pos == 4 + 8*m_cnt) m_pos = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        rx_data = b;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        model_byte(b);
        compare(req);
    endtask

    task automatic handle_apply();
        @(negedge clk);
        m_start = 0;
        chk(apply_start == 1'b0, "R8 pulse width", apply_start, 0);
        chk(apply_busy == 1'b1, "R8 busy held", apply_busy, 1);
        chk(rx_ready == 1'b0, "R8 ready low", rx_ready, 0);
        rx_valid = 1'b1;
        rx_data = TAG;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(rx_ready == 1'b0, "R8 byte refused while busy", rx_ready, 0);
            compare("R8");
        end
        rx_valid = 1'b0;
        apply_done = 1'b1;
        @(negedge clk);
        apply_done = 1'b0;
        m_busy = 0;
        chk(rx_ready == 1'b1, "R8 ready after done", rx_ready, 1);
        compare("R8 after done");
    endtask

    function automatic logic [63:0] gen(input int seed, input int i);
        return {32'(seed * 32'h9E37 + i * 32'h1F3 + 32'hC3000000),
                32'(32'hA5A50000 ^ (seed << 8) ^ (i * 32'h01010101))};
    endfunction

    task automatic send_frame(input logic [7:0] tag, input logic [7:0] flags,
                              input int cnt, input int seed, input string req);
        send_byte(tag, {req, " R1 tag"});
        send_byte(flags, {req, " R1 flags"});
        send_byte(8'(cnt), {req, " R1 count"});
        send_byte(8'(cnt >> 8), {req, " R1 count"});
        for (int i = 0; i < cnt; i++) begin
            logic [63:0] w;
            w = gen(seed, i);
            for (int k = 0; k < 8; k++) send_byte(w[k*8 +: 8], {req, " R2 payload"});
        end
        if (m_start) handle_apply();
    endtask

    task automatic check_table(input string req);
        for (int a = 0; a < N; a++) begin
            tbl_rd_addr = 5'(a);
            #1;
            chk(tbl_rd_data == m_tab[a], {req, " R9 table entry"}, tbl_rd_data, m_tab[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(rx_ready == 1'b1, "R8 reset ready", rx_ready, 1);
        compare("R8 reset");
        check_table("R9 reset");

        // R11: split 12/12/8 transfer
        send_frame(TAG, 8'h01, 12, 1, "R11 first");
        send_frame(TAG, 8'h00, 12, 1000, "R11 middle");
        send_frame(TAG, 8'h02, 8, 2000, "R11 last");
        check_table("R11 R2");

        // R10: whole table in one frame
        send_frame(TAG, 8'h03, 32, 2, "R10");
        check_table("R10");

        // R4: foreign tag with end flag and payload
        send_frame(8'h7E, 8'h03, 5, 9, "R4 foreign");
        check_table("R4");

        // R5: frames without begin and no open transfer
        send_frame(TAG, 8'h00, 2, 10, "R5 orphan middle");
        send_frame(TAG, 8'h02, 1, 11, "R5 orphan end");
        check_table("R5");

        // R3 clears error, R6 overflow
        send_frame(TAG, 8'h01, 20, 3, "R3 begin clears error");
        send_frame(TAG, 8'h00, 13, 12, "R6 overflow");
        send_frame(TAG, 8'h00, 1, 13, "R5 after overflow");
        check_table("R6");

        // R3: begin rewinds the pointer mid-transfer
        send_frame(TAG, 8'h01, 8, 4, "R3 first begin");
        send_frame(TAG, 8'h01, 24, 5, "R3 rewind");
        send_frame(TAG, 8'h02, 8, 6, "R3 end");
        check_table("R3");

        // R7: end flag with a short table
        send_frame(TAG, 8'h03, 10, 7, "R7 short end");
        check_table("R7");

        // R7: zero-count frames, end at header
        send_frame(TAG, 8'h01, 0, 0, "R7 empty begin");
        send_frame(TAG, 8'h00, 32, 8, "R7 fill");
        send_frame(TAG, 8'h02, 0, 0, "R7 empty end");
        check_table("R7 empty end");

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule